// File: doc/BRIEF.md
# UART Receive Character Buffer

This block sits between a UART receive shift register and the CPU bus. Each completed character arrives as a one-cycle strobe carrying eight data bits and a flag. The flag says whether the character failed its parity check. The block stores characters in one of two ways, chosen by a mode input:

- **Holding-register mode:** a single register holds one character.
- **FIFO mode:** a 16-entry queue holds characters in arrival order.

The block keeps three line-status flags:

- **ready:** at least one unread character is stored.
- **overrun:** a character arrived with no room for it.
- **parity error:** the character at the head of the buffer failed its parity check.

The CPU sees two values. The data value is always presented, and a data read strobe consumes it. The status byte is also always presented, and a status read strobe acknowledges the sticky flags.

The overrun rule depends on the mode. In holding-register mode, a new character that completes while the previous one is still unread overwrites it. In FIFO mode, overrun happens only when a character completes while all 16 entries are occupied. That character is dropped and the stored ones stay intact. In both modes, a read in the same cycle frees the room first.

Top module: `rx_char_buffer`

## Requirements
- R1: After reset the status byte reads 0x00 and the data output reads 0x00.
- R2: Status bit 0 (ready) is 1 while at least one stored character is unread. It returns to 0 once every stored character has been consumed by data reads.
- R3: With `fifo_en`=0 the buffer holds one character. A character completing while one is unread replaces it, so the data output shows the newer one, and status bit 1 (overrun) is set.
- R4: With `fifo_en`=1 up to 16 characters are stored and read out in arrival order.
- R5: With `fifo_en`=1 and all 16 entries occupied, a further character sets status bit 1, is discarded, and leaves the 16 stored characters unchanged.
- R6: A character completing in the same cycle as a data read of a full buffer is accepted without setting overrun, in either mode.
- R7: Status bit 2 (parity error) shows the parity-fail flag (`char_perr`=1 means mismatch) of the character at the head of the buffer. It is 0 when the buffer is empty. A status read clears it for that character only, and later characters report their own flag.
- R8: A status read clears the overrun flag. If an overrun occurs in the same cycle as the status read, the flag is set.
- R9: A data read while the buffer is empty changes no state. When the buffer is empty the data output shows the last character consumed (0x00 if none).
- R10: A change of `fifo_en` empties the buffer. A character completing in that same cycle is kept as the only stored character.
- R11: Status bits 7 to 3 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1 selects the 16-entry queue, 0 the single holding register |
| char_valid | input | 1 | One-cycle strobe: a character has completed |
| char_data | input | 8 | Completed character |
| char_perr | input | 1 | 1 when the completed character failed its parity check |
| rd_data | input | 1 | Data read strobe; consumes the head character |
| rd_status | input | 1 | Status read strobe; acknowledges overrun and head parity error |
| data_out | output | 8 | Head character, or last consumed character when empty |
| status_out | output | 8 | {5'b0, parity error, overrun, ready} |

## Verification
The bench targets these corner cases:

- **Overrun on the 17th character.** A design that treated the 16th character as an overrun, or that wrote the 17th over a stored entry, would show a wrong flag or a corrupted readout order.
- **A read in the same cycle as an arriving character.** A design that checked fullness before the read would raise a false overrun.
- **A status read in the same cycle as an overrun.** If the clear won over the set, the overrun event would be lost.
- **Parity flag on a mid-queue character.** A flag that was sticky rather than tied to the head would show on the wrong characters.
- **Mode change with a character arriving.** A design that let the flush win would drop that character.

// File: rtl/rxb_pkg.sv
`timescale 1ns/1ps
package rxb_pkg;

    localparam int ST_READY   = 0;
    localparam int ST_OVERRUN = 1;
    localparam int ST_PERR    = 2;
    localparam int ST_WIDTH   = 8;

    // Command word from the controller to the storage
    typedef struct packed {
        logic flush;      // empty the buffer (mode change)
        logic push;       // append a character at the tail
        logic overwrite;  // replace the head (holding mode overrun)
        logic pop;        // consume the head
        logic ack_perr;   // clear the head parity flag
    } store_cmd_t;

endpackage

// File: rtl/rxb_store.sv
`timescale 1ns/1ps
module rxb_store
    import rxb_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  store_cmd_t                     cmd,
    input  logic [W-1:0]                   wdata,
    input  logic                           wperr,
    output logic [W-1:0]                   head_data,
    output logic                           head_perr,
    output logic [$clog2(DEPTH+1)-1:0]     count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [DEPTH-1:0]        perr;
        logic [PW-1:0]           rd_ptr;
        logic [PW-1:0]           wr_ptr;
        logic [CW-1:0]           count;
    } store_state_t;

    store_state_t st_d, st_q;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        if (p == PW'(DEPTH - 1)) return '0;
        return p + PW'(1);
    endfunction

    always_comb begin
        logic [PW-1:0] wr_base;
        st_d    = st_q;
        wr_base = st_q.wr_ptr;
        if (cmd.flush) begin
            st_d.rd_ptr = '0;
            st_d.wr_ptr = '0;
            wr_base     = '0;
            st_d.count  = cmd.push ? CW'(1) : '0;
        end else begin
            if (cmd.ack_perr) begin
                st_d.perr[st_q.rd_ptr] = 1'b0;
            end
            if (cmd.pop) begin
                st_d.rd_ptr = ptr_next(st_q.rd_ptr);
            end
            if (cmd.overwrite) begin
                st_d.mem[st_q.rd_ptr]  = wdata;
                st_d.perr[st_q.rd_ptr] = wperr;
            end
            st_d.count = st_q.count + CW'(cmd.push) - CW'(cmd.pop);
        end
        if (cmd.push) begin
            st_d.mem[wr_base]  = wdata;
            st_d.perr[wr_base] = wperr;
            st_d.wr_ptr        = ptr_next(wr_base);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_data = st_q.mem[st_q.rd_ptr];
    assign head_perr = st_q.perr[st_q.rd_ptr];
    assign count     = st_q.count;

    // R2: a consume only ever happens when something is stored
    a_r2_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.pop |-> (st_q.count != '0));

    // R4: occupancy never exceeds the storage depth
    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CW'(DEPTH));

    // R5: a full buffer with no consume and no flush stays full
    a_r5_full_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.count == CW'(DEPTH) && !cmd.pop && !cmd.flush)
        |=> (st_q.count == CW'(DEPTH)));

endmodule

// File: rtl/rxb_ctrl.sv
`timescale 1ns/1ps
module rxb_ctrl
    import rxb_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fifo_en,
    input  logic                       char_valid,
    input  logic                       rd_data,
    input  logic                       rd_status,
    input  logic [$clog2(DEPTH+1)-1:0] count,
    output store_cmd_t                 cmd,
    output logic                       overrun
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic mode;
        logic overrun;
    } ctrl_state_t;

    ctrl_state_t cs_d, cs_q;
    logic        ovr_event;

    always_comb begin
        logic mode_chg, empty, full, blocked;
        mode_chg = (fifo_en != cs_q.mode);
        empty    = (count == '0);
        full     = fifo_en ? (count == CW'(DEPTH)) : !empty;

        cmd.flush     = mode_chg;
        cmd.pop       = rd_data && !empty && !mode_chg;
        cmd.ack_perr  = rd_status && !empty && !mode_chg;
        blocked       = full && !cmd.pop && !mode_chg;
        cmd.push      = char_valid && !blocked;
        cmd.overwrite = char_valid && blocked && !fifo_en;
        ovr_event     = char_valid && blocked;

        cs_d      = cs_q;
        cs_d.mode = fifo_en;
        if (ovr_event)      cs_d.overrun = 1'b1;
        else if (rd_status) cs_d.overrun = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign overrun = cs_q.overrun;

    // R5: queue mode never appends to a full buffer without a consume
    a_r5_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && count == CW'(DEPTH) && !cmd.pop && !cmd.flush) |-> !cmd.push);

    // R3: holding mode keeps at most one character
    a_r3_hold_single: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_q.mode) |-> (count <= CW'(1)));

    // R8: an overrun event is visible in the next cycle
    a_r8_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_event |=> overrun);

    // R8: a status read without an overrun event clears the flag
    a_r8_overrun_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && !ovr_event) |=> !overrun);

    // R3/R5: the drop/overwrite decision never happens together with a flush
    a_r10_flush_excl: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.flush |-> !(cmd.overwrite || cmd.pop || cmd.ack_perr));

endmodule

// File: rtl/rx_char_buffer.sv
`timescale 1ns/1ps
module rx_char_buffer
    import rxb_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          char_valid,
    input  logic [W-1:0]  char_data,
    input  logic          char_perr,
    input  logic          rd_data,
    input  logic          rd_status,
    output logic [W-1:0]  data_out,
    output logic [7:0]    status_out
);
    localparam int CW = $clog2(DEPTH + 1);

    store_cmd_t      cmd;
    logic [W-1:0]    head_data;
    logic            head_perr;
    logic [CW-1:0]   count;
    logic            overrun;
    logic [W-1:0]    last_d, last_q;
    logic            empty;

    rxb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_en    (fifo_en),
        .char_valid (char_valid),
        .rd_data    (rd_data),
        .rd_status  (rd_status),
        .count      (count),
        .cmd        (cmd),
        .overrun    (overrun)
    );

    rxb_store #(.DEPTH(DEPTH), .W(W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .wdata     (char_data),
        .wperr     (char_perr),
        .head_data (head_data),
        .head_perr (head_perr),
        .count     (count)
    );

    assign empty = (count == '0);

    always_comb begin
        last_d = last_q;
        if (cmd.pop) last_d = head_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= '0;
        else        last_q <= last_d;
    end

    assign data_out = empty ? last_q : head_data;

    always_comb begin
        status_out             = '0;
        status_out[ST_READY]   = !empty;
        status_out[ST_OVERRUN] = overrun;
        status_out[ST_PERR]    = !empty && head_perr;
    end

    // R9: a data read of an empty buffer leaves the presented data unchanged
    a_r9_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && empty && fifo_en == $past(fifo_en) && !char_valid)
        |=> $stable(data_out));

    // R11: reserved status bits stay low
    a_r11_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        status_out[7:3] == 5'b0);

endmodule

// File: tb/rx_char_buffer_tb.sv
`timescale 1ns/1ps
module rx_char_buffer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0;
    logic       char_valid = 1'b0;
    logic [7:0] char_data = '0;
    logic       char_perr = 1'b0;
    logic       rd_data = 1'b0;
    logic       rd_status = 1'b0;
    logic [7:0] data_out;
    logic [7:0] status_out;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    rx_char_buffer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_en    (fifo_en),
        .char_valid (char_valid),
        .char_data  (char_data),
        .char_perr  (char_perr),
        .rd_data    (rd_data),
        .rd_status  (rd_status),
        .data_out   (data_out),
        .status_out (status_out)
    );

    // Vector: {req[3:0], fifo_en, cv, data[7:0], perr, rd_data, rd_status,
    //          expected status[7:0], expected data[7:0]} checked before the edge
    localparam int NV = 16;
    localparam logic [32:0] VEC [NV] = '{
        {4'd1,  1'b0,1'b0,8'h00,1'b0,1'b0,1'b0, 8'h00,8'h00}, // R1 reset state
        {4'd2,  1'b0,1'b1,8'hA5,1'b0,1'b0,1'b0, 8'h00,8'h00}, // R2 arrive
        {4'd2,  1'b0,1'b0,8'h00,1'b0,1'b0,1'b0, 8'h01,8'hA5}, // R2 ready
        {4'd3,  1'b0,1'b1,8'h3C,1'b1,1'b0,1'b0, 8'h01,8'hA5}, // R3 overwrite
        {4'd3,  1'b0,1'b0,8'h00,1'b0,1'b0,1'b0, 8'h07,8'h3C}, // R3 R7 flags
        {4'd8,  1'b0,1'b0,8'h00,1'b0,1'b0,1'b1, 8'h07,8'h3C}, // R8 status read
        {4'd7,  1'b0,1'b0,8'h00,1'b0,1'b0,1'b0, 8'h01,8'h3C}, // R7 R8 cleared
        {4'd2,  1'b0,1'b0,8'h00,1'b0,1'b1,1'b0, 8'h01,8'h3C}, // R2 consume
        {4'd2,  1'b0,1'b0,8'h00,1'b0,1'b0,1'b0, 8'h00,8'h3C}, // R2 empty
        {4'd9,  1'b0,1'b0,8'h00,1'b0,1'b1,1'b0, 8'h00,8'h3C}, // R9 empty read
        {4'd9,  1'b0,1'b0,8'h00,1'b0,1'b0,1'b0, 8'h00,8'h3C}, // R9 unchanged
        {4'd8,  1'b0,1'b1,8'h11,1'b0,1'b0,1'b1, 8'h00,8'h3C}, // R8 read no ovr
        {4'd6,  1'b0,1'b1,8'h22,1'b0,1'b1,1'b0, 8'h01,8'h11}, // R6 read+arrive
        {4'd6,  1'b0,1'b1,8'h33,1'b0,1'b0,1'b1, 8'h01,8'h22}, // R6 no ovr; R8 set wins
        {4'd8,  1'b0,1'b0,8'h00,1'b0,1'b0,1'b0, 8'h03,8'h33}, // R8 set kept
        {4'd11, 1'b0,1'b0,8'h00,1'b0,1'b0,1'b0, 8'h03,8'h33}  // R11 reserved zero
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    // One cycle of stimulus; strobes drop after the edge
    task automatic cyc(input logic fe, input logic cv, input logic [7:0] d,
                       input logic pe, input logic rdd, input logic rds);
        @(negedge clk);
        fifo_en = fe; char_valid = cv; char_data = d; char_perr = pe;
        rd_data = rdd; rd_status = rds;
        @(posedge clk);
        #1;
        char_valid = 1'b0; rd_data = 1'b0; rd_status = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #4_000_000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 directed reset check
        #1;
        check("R1 status", status_out, 8'h00);
        check("R1 data", data_out, 8'h00);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            fifo_en    = VEC[i][28];
            char_valid = VEC[i][27];
            char_data  = VEC[i][26:19];
            char_perr  = VEC[i][18];
            rd_data    = VEC[i][17];
            rd_status  = VEC[i][16];
            #1;
            check($sformatf("R%0d vec%0d status", VEC[i][32:29], i), status_out, VEC[i][15:8]);
            check($sformatf("R%0d vec%0d data", VEC[i][32:29], i), data_out, VEC[i][7:0]);
            @(posedge clk);
            #1;
        end
        char_valid = 1'b0; rd_data = 1'b0; rd_status = 1'b0;

        // R10 switching to queue mode flushes the held character
        cyc(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        check("R10 flush status", status_out, 8'h02);
        check("R10 flush data", data_out, 8'h11);
        cyc(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);

        // R4 fill sixteen entries, parity fail on the fourth
        for (int i = 0; i < 16; i++)
            cyc(1'b1, 1'b1, 8'h40 + 8'(i), (i == 3), 1'b0, 1'b0);
        check("R4 full status", status_out, 8'h01);
        check("R4 head", data_out, 8'h40);
        // R5 seventeenth character overruns and is dropped
        cyc(1'b1, 1'b1, 8'hEE, 1'b0, 1'b0, 1'b0);
        check("R5 overrun", status_out, 8'h03);
        cyc(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        check("R8 cleared", status_out, 8'h01);
        for (int i = 0; i < 16; i++) begin
            check("R4 R5 order", data_out, 8'h40 + 8'(i));
            check("R7 head parity", status_out, (i == 3) ? 8'h05 : 8'h01);
            cyc(1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
        end
        check("R2 drained", status_out, 8'h00);
        check("R9 last", data_out, 8'h4F);
        cyc(1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
        check("R9 empty read status", status_out, 8'h00);
        check("R9 empty read data", data_out, 8'h4F);

        // R7 status read clears the head flag only
        cyc(1'b1, 1'b1, 8'h61, 1'b1, 1'b0, 1'b0);
        cyc(1'b1, 1'b1, 8'h62, 1'b1, 1'b0, 1'b0);
        check("R7 head set", status_out, 8'h05);
        cyc(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        check("R7 acked", status_out, 8'h01);
        cyc(1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
        check("R7 next own flag", status_out, 8'h05);
        cyc(1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
        check("R7 empty", status_out, 8'h00);

        // R6 full queue with read and arrival in the same cycle
        for (int i = 0; i < 16; i++)
            cyc(1'b1, 1'b1, 8'h80 + 8'(i), 1'b0, 1'b0, 1'b0);
        cyc(1'b1, 1'b1, 8'hEE, 1'b0, 1'b1, 1'b0);
        check("R6 no overrun", status_out, 8'h01);
        for (int i = 1; i < 17; i++) begin
            check("R6 order", data_out, (i == 16) ? 8'hEE : 8'h80 + 8'(i));
            cyc(1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
        end
        check("R6 drained", status_out, 8'h00);

        // R10 mode change with a character arriving in the same cycle
        cyc(1'b1, 1'b1, 8'h10, 1'b0, 1'b0, 1'b0);
        cyc(1'b1, 1'b1, 8'h20, 1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b1, 8'h5A, 1'b0, 1'b0, 1'b0);
        check("R10 kept status", status_out, 8'h01);
        check("R10 kept data", data_out, 8'h5A);
        cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
        check("R10 single entry", status_out, 8'h00);

        finish_run();
    end

endmodule